// File: doc/BRIEF.md
# Programmable Core Power Sequencer

This block sits in the always-on domain next to a single processor core. It carries that core into a low-power idle state and brings it back out. The core first executes its wait-for-interrupt instruction and stops its own clock, then raises a trigger. The sequencer then walks a short byte-coded program chosen from several programs stored in a small local memory. Each step either drives the core's power controls (isolation clamp, power switch, retention, clock hold), waits a fixed number of cycles, issues a voltage request to the regulator, signals or waits on the system power controller, or waits for the wake interrupt. When the program ends, the core is released through a level handshake.

Firmware loads the programs through a plain write port while the sequencer is idle, and picks the program for the next entry with a select input. The sequencer keeps its state while the core is unpowered. Its status outputs give the step index, the program in use and a flag telling whether the core's power switch was opened during the last sequence, so the wake-up code can choose a warm-boot path.

Top module: `pwr_step_seq`

## Requirements
- R1: While idle, a high `core_wfi` at a clock edge starts a sequence; `sel_state` is captured at that edge, and later changes to it do not affect the running sequence or `st_idx`.
- R2: `cfg_addr` holds the program number in its upper 2 bits and the step number (0 to 31) in its lower 5 bits; a write made while `busy` is high has no effect on the stored step.
- R3: Each step byte carries the opcode in bits 7:4 and the argument in bits 3:0; opcode 1 copies the argument into `ctl_out` (bit 0 clamp, bit 1 power switch open, bit 2 retention, bit 3 clock hold), which holds until the next opcode-1 step.
- R4: Opcode 2 delays the next step by exactly its argument in cycles: two opcode-1 steps placed around it change `ctl_out` 4 + argument cycles apart.
- R5: Opcode 3 stalls the sequence until `wake_irq` is high.
- R6: Opcode 4 produces a one-cycle pulse on `pc_notify`; opcode 5 stalls the sequence until `pc_ack` is high.
- R7: Opcode 6 raises `vreg_req` with `vreg_level` equal to the argument, both held unchanged until `vreg_ack` is seen, after which `vreg_req` drops.
- R8: Opcode 0, or finishing step 31, raises `core_release`; it stays high while `core_wfi` is high, and once `core_wfi` is low the block returns to idle with `core_release` and `busy` low.
- R9: If `wake_irq` is already high in the cycle the sequence starts, every step up to and including the first opcode-3 step is passed over without effect.
- R10: `st_pc` shows the index of the current step (the final step while released), `st_idx` the program in use, and `st_off` is set when an executed opcode-1 step has argument bit 1 high; `st_off` clears when the next sequence starts.
- R11: After reset the block is idle with `busy`, `core_release`, `pc_notify`, `vreg_req`, `ctl_out`, `st_pc` and `st_off` all zero.
- R12: Opcodes 7 to 15 change no output and the sequence continues with the next step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Always-on clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Program memory write strobe |
| cfg_addr | input | 7 | Program number and step number of the write |
| cfg_wdata | input | 8 | Step byte to store |
| sel_state | input | 2 | Program to run at the next entry |
| core_wfi | input | 1 | Core is in WFI with its clock stopped |
| core_release | output | 1 | Core may resume; held until `core_wfi` drops |
| wake_irq | input | 1 | Wake interrupt from the interrupt controller |
| pc_notify | output | 1 | One-cycle interrupt to the system power controller |
| pc_ack | input | 1 | System power controller reports dependencies ready |
| ctl_out | output | 4 | Core power controls: clamp, switch, retention, clock hold |
| vreg_req | output | 1 | Voltage change request to the regulator |
| vreg_level | output | 4 | Requested voltage code |
| vreg_ack | input | 1 | Regulator has applied the request |
| busy | output | 1 | A sequence is running or awaiting release |
| st_pc | output | 5 | Current step index |
| st_idx | output | 2 | Program in use |
| st_off | output | 1 | Core power switch was opened in this sequence |

## Verification
The wake interrupt and the start trigger can land in the same cycle, and that coincidence decides whether the power-down half of the program runs at all. The bench raises `wake_irq` at the same falling edge as `core_wfi` for two programs and judges the result at the ports: the notify pulse count, the regulator request count, the final `ctl_out` and a cleared `st_off` must match a run in which the skipped steps never took place. A second collision, a program write arriving while the sequence is stalled, is judged by the control value the overwritten step later leaves on `ctl_out`.

// File: rtl/pss_pkg.sv
package pss_pkg;
  localparam int BYTE_W = 8;
  localparam int ARG_W  = 4;
  localparam int CTL_W  = 4;

  localparam logic [3:0] OP_END  = 4'h0;
  localparam logic [3:0] OP_SET  = 4'h1;
  localparam logic [3:0] OP_DLY  = 4'h2;
  localparam logic [3:0] OP_WAKE = 4'h3;
  localparam logic [3:0] OP_NOTE = 4'h4;
  localparam logic [3:0] OP_WACK = 4'h5;
  localparam logic [3:0] OP_VREQ = 4'h6;

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_EXEC, S_DLY, S_WWAKE, S_WACK, S_WVREG, S_DONE
  } seq_st_e;
endpackage

// File: rtl/pss_seq_mem.sv
module pss_seq_mem #(
  parameter int AW = 7,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // single write port, registered read: maps onto one block RAM
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/pss_interp.sv
module pss_interp
  import pss_pkg::*;
#(
  parameter int IDX_W   = 2,
  parameter int PC_W    = 5,
  parameter int STEPS   = 32,
  parameter int OFF_BIT = 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  core_wfi,
  input  logic [IDX_W-1:0]      sel_state,
  input  logic                  wake_irq,
  input  logic                  pc_ack,
  input  logic                  vreg_ack,
  input  logic [BYTE_W-1:0]     step_byte,
  output logic [IDX_W+PC_W-1:0] rd_addr,
  output logic                  busy,
  output logic                  core_release,
  output logic [CTL_W-1:0]      ctl_out,
  output logic                  pc_notify,
  output logic                  vreg_req,
  output logic [ARG_W-1:0]      vreg_level,
  output logic [PC_W-1:0]       st_pc,
  output logic [IDX_W-1:0]      st_idx,
  output logic                  st_off
);
  localparam logic [PC_W-1:0] LAST = PC_W'(STEPS - 1);

  seq_st_e          st;
  logic [IDX_W-1:0] idx;
  logic [PC_W-1:0]  pc;
  logic [ARG_W-1:0] cnt;
  logic             skip;
  logic             off;
  logic [3:0]       op;
  logic [ARG_W-1:0] arg;
  logic             step_ok;
  logic             adv;
  logic             fin;

  assign op      = step_byte[7:4];
  assign arg     = step_byte[3:0];
  assign rd_addr = {idx, pc};
  assign busy    = (st != S_IDLE);
  assign st_pc   = pc;
  assign st_idx  = idx;
  assign st_off  = off;

  // step completion: does the current step hand over to the next one
  always_comb begin
    step_ok = 1'b0;
    fin     = 1'b0;
    unique case (st)
      S_EXEC: begin
        if (op == OP_END) fin = 1'b1;
        else if (skip)    step_ok = 1'b1;
        else begin
          unique case (op)
            OP_DLY:                    step_ok = (arg == '0);
            OP_WAKE, OP_WACK, OP_VREQ: step_ok = 1'b0;
            default:                   step_ok = 1'b1;
          endcase
        end
      end
      S_DLY:   step_ok = (cnt == ARG_W'(1));
      S_WWAKE: step_ok = wake_irq;
      S_WACK:  step_ok = pc_ack;
      S_WVREG: step_ok = vreg_ack;
      default: step_ok = 1'b0;
    endcase
    adv = step_ok && (pc != LAST);
    if (step_ok && (pc == LAST)) fin = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st           <= S_IDLE;
      idx          <= '0;
      pc           <= '0;
      cnt          <= '0;
      skip         <= 1'b0;
      off          <= 1'b0;
      ctl_out      <= '0;
      pc_notify    <= 1'b0;
      vreg_req     <= 1'b0;
      vreg_level   <= '0;
      core_release <= 1'b0;
    end else begin
      pc_notify <= 1'b0;
      unique case (st)
        S_IDLE: begin
          if (core_wfi) begin
            idx  <= sel_state;
            pc   <= '0;
            skip <= wake_irq;
            off  <= 1'b0;
            st   <= S_FETCH;
          end
        end
        S_FETCH: st <= S_EXEC;
        S_EXEC: begin
          if (skip) begin
            if (op == OP_WAKE) skip <= 1'b0;
          end else begin
            unique case (op)
              OP_SET: begin
                ctl_out <= arg;
                if (arg[OFF_BIT]) off <= 1'b1;
              end
              OP_DLY: begin
                cnt <= arg;
                if (arg != '0) st <= S_DLY;
              end
              OP_WAKE: st <= S_WWAKE;
              OP_NOTE: pc_notify <= 1'b1;
              OP_WACK: st <= S_WACK;
              OP_VREQ: begin
                vreg_req   <= 1'b1;
                vreg_level <= arg;
                st         <= S_WVREG;
              end
              default: ;
            endcase
          end
        end
        S_DLY:   cnt <= cnt - ARG_W'(1);
        S_WVREG: if (vreg_ack) vreg_req <= 1'b0;
        S_DONE: begin
          if (!core_wfi) begin
            core_release <= 1'b0;
            st           <= S_IDLE;
          end
        end
        default: ;
      endcase
      if (fin) begin
        st           <= S_DONE;
        core_release <= 1'b1;
      end else if (adv) begin
        pc <= pc + PC_W'(1);
        st <= S_FETCH;
      end
    end
  end

  AST_START_WFI: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(core_wfi)); // R1
  AST_IDX_HELD: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(idx)); // R1
  AST_WAKE_GATE: assert property (@(posedge clk) disable iff (rst)
    (st == S_WWAKE && !wake_irq) |=> (st == S_WWAKE)); // R5
  AST_NOTIFY_PULSE: assert property (@(posedge clk) disable iff (rst)
    pc_notify |=> !pc_notify); // R6
  AST_ACK_GATE: assert property (@(posedge clk) disable iff (rst)
    (st == S_WACK && !pc_ack) |=> (st == S_WACK && !core_release)); // R6
  AST_VREQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (vreg_req && !vreg_ack) |=> (vreg_req && $stable(vreg_level))); // R7
  AST_RELEASE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (core_release && core_wfi) |=> core_release); // R8
endmodule

// File: rtl/pwr_step_seq.sv
module pwr_step_seq
  import pss_pkg::*;
#(
  parameter int N_IDLE  = 4,
  parameter int STEPS   = 32,
  parameter int OFF_BIT = 1,
  localparam int IDX_W  = $clog2(N_IDLE),
  localparam int PC_W   = $clog2(STEPS),
  localparam int AW     = IDX_W + PC_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [AW-1:0]     cfg_addr,
  input  logic [BYTE_W-1:0] cfg_wdata,
  input  logic [IDX_W-1:0]  sel_state,
  input  logic              core_wfi,
  output logic              core_release,
  input  logic              wake_irq,
  output logic              pc_notify,
  input  logic              pc_ack,
  output logic [CTL_W-1:0]  ctl_out,
  output logic              vreg_req,
  output logic [ARG_W-1:0]  vreg_level,
  input  logic              vreg_ack,
  output logic              busy,
  output logic [PC_W-1:0]   st_pc,
  output logic [IDX_W-1:0]  st_idx,
  output logic              st_off
);
  logic [AW-1:0]     rd_addr;
  logic [BYTE_W-1:0] step_byte;
  logic              mem_we;

  // programs are frozen while a sequence owns the memory
  assign mem_we = cfg_we && !busy;

  pss_seq_mem #(.AW(AW), .DW(BYTE_W)) u_mem (
    .clk   (clk),
    .we    (mem_we),
    .waddr (cfg_addr),
    .wdata (cfg_wdata),
    .raddr (rd_addr),
    .rdata (step_byte)
  );

  pss_interp #(
    .IDX_W(IDX_W), .PC_W(PC_W), .STEPS(STEPS), .OFF_BIT(OFF_BIT)
  ) u_interp (
    .clk          (clk),
    .rst          (rst),
    .core_wfi     (core_wfi),
    .sel_state    (sel_state),
    .wake_irq     (wake_irq),
    .pc_ack       (pc_ack),
    .vreg_ack     (vreg_ack),
    .step_byte    (step_byte),
    .rd_addr      (rd_addr),
    .busy         (busy),
    .core_release (core_release),
    .ctl_out      (ctl_out),
    .pc_notify    (pc_notify),
    .vreg_req     (vreg_req),
    .vreg_level   (vreg_level),
    .st_pc        (st_pc),
    .st_idx       (st_idx),
    .st_off       (st_off)
  );
endmodule

// File: tb/tb_pwr_step_seq.sv
`timescale 1ns/1ps
module tb_pwr_step_seq;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_we = 1'b0;
  logic [6:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic [1:0] sel_state = '0;
  logic       core_wfi = 1'b0;
  logic       wake_irq = 1'b0;
  logic       pc_ack = 1'b0;
  logic       vreg_ack = 1'b0;
  logic       core_release, pc_notify, vreg_req, busy, st_off;
  logic [3:0] ctl_out, vreg_level;
  logic [4:0] st_pc;
  logic [1:0] st_idx;

  int n_cmp = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  pwr_step_seq dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .sel_state(sel_state), .core_wfi(core_wfi),
    .core_release(core_release), .wake_irq(wake_irq), .pc_notify(pc_notify),
    .pc_ack(pc_ack), .ctl_out(ctl_out), .vreg_req(vreg_req),
    .vreg_level(vreg_level), .vreg_ack(vreg_ack), .busy(busy),
    .st_pc(st_pc), .st_idx(st_idx), .st_off(st_off)
  );

  typedef struct packed {
    logic [1:0] idx;
    logic       pre;
    logic [3:0] nt;
    logic       off;
    logic [3:0] ctl;
    logic [4:0] pc;
    logic [3:0] vr;
  } vec_t;

  // program, wake-already-pending, notifies, off flag, final ctl, final step, voltage requests
  localparam logic [20:0] VECS [6] = '{
    {2'd0, 1'b0, 4'd0, 1'b0, 4'h0, 5'd3,  4'd0},
    {2'd1, 1'b0, 4'd2, 1'b1, 4'h0, 5'd9,  4'd1},
    {2'd2, 1'b0, 4'd0, 1'b0, 4'h0, 5'd7,  4'd2},
    {2'd3, 1'b0, 4'd0, 1'b1, 4'h2, 5'd31, 4'd0},
    {2'd1, 1'b1, 4'd1, 1'b0, 4'h0, 5'd9,  4'd1},
    {2'd0, 1'b1, 4'd0, 1'b0, 4'h0, 5'd3,  4'd0}
  };

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int prog, input int step, input logic [7:0] data);
    @(negedge clk);
    cfg_we    = 1'b1;
    cfg_addr  = {prog[1:0], step[4:0]};
    cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic let_go();
    core_wfi = 1'b0;
    wake_irq = 1'b0;
    vreg_ack = 1'b0;
    repeat (2) @(negedge clk);
    chk("R8 idle after release", {busy, core_release}, 0);
  endtask

  task automatic run_vec(input vec_t v);
    int  nt = 0;
    int  vr = 0;
    bit  got = 0;
    bit  prev_req = 0;
    @(negedge clk);
    sel_state = v.idx;
    pc_ack    = 1'b1;
    wake_irq  = v.pre;
    core_wfi  = 1'b1;
    @(negedge clk);
    sel_state = ~v.idx;
    for (int c = 0; c < 400 && !got; c++) begin
      @(negedge clk);
      if (c == 12) wake_irq = 1'b1;
      if (pc_notify) nt++;
      if (vreg_req && !prev_req) vr++;
      prev_req = vreg_req;
      vreg_ack = vreg_req;
      if (core_release) got = 1;
    end
    chk("R8 release reached", int'(got), 1);
    chk("R1 st_idx latched", st_idx, v.idx);
    chk("R10 final st_pc", st_pc, v.pc);
    chk("R10 st_off", st_off, v.off);
    chk("R3 final ctl_out", ctl_out, v.ctl);
    chk("R7 voltage request count", vr, v.vr);
    if (v.pre) chk("R9 notify count when skipping", nt, v.nt);
    else       chk("R6 notify count", nt, v.nt);
    repeat (3) @(negedge clk);
    chk("R8 release held while wfi high", {busy, core_release}, 3);
    let_go();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired (R8 sequence never finished)");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int w;
    bit got;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R11 reset outputs", {busy, core_release, pc_notify, vreg_req, st_off}, 0);
    chk("R11 reset ctl_out", ctl_out, 0);
    chk("R11 reset st_pc", st_pc, 0);
    repeat (8) @(negedge clk);
    chk("R1 no start without wfi", busy, 0);

    // program 0: light idle
    wr(0, 0, 8'h18); wr(0, 1, 8'h30); wr(0, 2, 8'h10); wr(0, 3, 8'h00);
    // program 1: full power-down with both controller handshakes
    wr(1, 0, 8'h11); wr(1, 1, 8'h13); wr(1, 2, 8'h40); wr(1, 3, 8'h30);
    wr(1, 4, 8'h6A); wr(1, 5, 8'h40); wr(1, 6, 8'h50); wr(1, 7, 8'h11);
    wr(1, 8, 8'h10); wr(1, 9, 8'h00);
    // program 2: retention, includes opcode F (R12)
    wr(2, 0, 8'h14); wr(2, 1, 8'h63); wr(2, 2, 8'h25); wr(2, 3, 8'h30);
    wr(2, 4, 8'h69); wr(2, 5, 8'h10); wr(2, 6, 8'hF0); wr(2, 7, 8'h00);
    // program 3: no end marker, filler opcode 7 (R12), runs off step 31
    wr(3, 0, 8'h30); wr(3, 1, 8'h12);
    for (int s = 2; s < 32; s++) wr(3, s, 8'h77);

    for (int i = 0; i < 6; i++) run_vec(vec_t'(VECS[i]));

    // R4: delay of 6 between two control steps
    wr(0, 0, 8'h11); wr(0, 1, 8'h26); wr(0, 2, 8'h10); wr(0, 3, 8'h00);
    @(negedge clk);
    pc_ack = 1'b1; sel_state = 2'd0; core_wfi = 1'b1;
    w = 0; got = 0;
    for (int c = 0; c < 60 && !got; c++) begin
      @(negedge clk);
      if (ctl_out == 4'h1) w++;
      if (core_release) got = 1;
    end
    chk("R4 ctl_out width around delay 6", w, 4 + 6);
    let_go();

    // R6/R5/R2: stall on ack, stall on wake, locked write
    wr(0, 0, 8'h40); wr(0, 1, 8'h50); wr(0, 2, 8'h30); wr(0, 3, 8'h00);
    @(negedge clk);
    pc_ack = 1'b0; wake_irq = 1'b0; core_wfi = 1'b1;
    w = 0;
    for (int c = 0; c < 20; c++) begin
      @(negedge clk);
      if (pc_notify) w++;
    end
    chk("R6 single notify pulse", w, 1);
    chk("R6 stalled at ack step", st_pc, 1);
    chk("R6 no release before ack", core_release, 0);
    pc_ack = 1'b1;
    repeat (6) @(negedge clk);
    chk("R5 stalled at wake step", st_pc, 2);
    chk("R5 no release before wake", core_release, 0);
    wr(0, 3, 8'h1F);
    repeat (4) @(negedge clk);
    wake_irq = 1'b1;
    got = 0;
    for (int c = 0; c < 20 && !got; c++) begin
      @(negedge clk);
      if (core_release) got = 1;
    end
    chk("R5 release after wake", int'(got), 1);
    chk("R2 write while busy ignored", ctl_out, 0);
    chk("R10 end step index", st_pc, 3);
    let_go();

    // R7: voltage request held until acknowledged
    wr(0, 0, 8'h65); wr(0, 1, 8'h00);
    @(negedge clk);
    vreg_ack = 1'b0; core_wfi = 1'b1;
    repeat (10) @(negedge clk);
    chk("R7 request held without ack", vreg_req, 1);
    chk("R7 requested level", vreg_level, 5);
    chk("R7 no release before ack", core_release, 0);
    vreg_ack = 1'b1;
    @(negedge clk);
    vreg_ack = 1'b0;
    got = 0;
    for (int c = 0; c < 20 && !got; c++) begin
      @(negedge clk);
      if (core_release) got = 1;
    end
    chk("R7 request dropped after ack", {vreg_req, got}, 1);
    let_go();

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule